// File: doc/BRIEF.md
# Threshold-Driven Data Buffer with DMA Requests

This block is a 32-word, 16-bit circular buffer that sits between a processor data port and a card-side transfer engine. In the receive direction the engine pushes words and the processor pops them; in the transmit direction the processor pushes and the engine pops. A single configuration word sets an almost-full level, an almost-empty level and a DMA enable for each direction.

From the fill count, the transfer direction and the transfer-active flag, the block drives two level flags and two DMA request lines. When the DMA enable for a direction is set, that direction's request line takes the place of its flag. The flags and requests are registered, so they follow the fill count one clock later. When no transfer is running and the buffer is empty, both flags are forced low.

Top module: `dma_thresh_fifo`

## Requirements
- R1: After reset the fill count is 0, all four flag and request outputs are 0, and the read data is 0. The configuration resets to an almost-full level of 31, an almost-empty level of 0 and both DMA enables off.
- R2: A push comes from either `cpuWr` (data `cpuWdata`) or `engPush` (data `engPushData`); when both are high, `cpuWdata` is taken. A pop comes from either `cpuRd` or `engPop`. `rdData` always shows the word at the head. Words leave in the order they entered, and the pointers wrap modulo 32.
- R3: A push while the count is 32 is discarded. The count stays at 32 and the stored words are unchanged.
- R4: A pop while the count is 0 leaves the count and both pointers unchanged, and `rdData` keeps showing the head word. The next push is therefore read back first.
- R5: A push and a pop that are both accepted in the same cycle leave the count unchanged.
- R6: The configuration word, written with `cfgWe`, holds the receive DMA enable in bit 15, the almost-full level in bits 12:8, the transmit DMA enable in bit 7 and the almost-empty level in bits 4:0. A receive hit means `xferDirRx`=1 and count > almost-full level. On a receive hit, `rxDmaReq`=1 and `rxLevelFlag`=0 when receive DMA is enabled; otherwise `rxLevelFlag`=1 and `rxDmaReq`=0. With no receive hit, both are 0.
- R7: A transmit hit means `xferDirRx`=0 and count < almost-empty level. On a transmit hit, `txDmaReq`=1 and `txLevelFlag`=0 when transmit DMA is enabled; otherwise `txLevelFlag`=1 and `txDmaReq`=0. With no transmit hit, both are 0.
- R8: When `xferActive`=0 and the count is 0, both level flags clear at the next edge, and both DMA requests keep their previous values.
- R9: A configuration write with a DMA enable bit set clears that direction's level flag at the same edge. The request lines evaluated at that edge still use the old configuration.
- R10: Flags and requests are registered. At an edge they take the value computed from the count and configuration held before that edge, so they trail a count change by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration word |
| xferActive | input | 1 | A transfer is in progress |
| xferDirRx | input | 1 | 1 = receive (card to processor), 0 = transmit |
| cpuWr | input | 1 | Processor push strobe |
| cpuWdata | input | 16 | Processor push data |
| cpuRd | input | 1 | Processor pop strobe |
| engPush | input | 1 | Engine push strobe |
| engPushData | input | 16 | Engine push data |
| engPop | input | 1 | Engine pop strobe |
| rdData | output | 16 | Word at the head |
| fillCount | output | 6 | Number of stored words, 0 to 32 |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| rxLevelFlag | output | 1 | Receive level flag |
| txLevelFlag | output | 1 | Transmit level flag |

## Verification
On every cycle, the assertions check the following:
- the count never passes 32, and no strobe is accepted into a full or out of an empty buffer;
- an accepted push together with an accepted pop holds the count;
- a flag and its request are never high together;
- the idle clear works and the requests hold while idle;
- a configuration write with an enable set clears the matching flag.

Only the bench scenarios can show:
- that data leaves in push order across the wrap;
- which word an empty pop exposes;
- that a dropped push leaves the contents intact;
- the exact one-clock lag of the flags behind the count at the threshold crossings.

// File: rtl/dma_thresh_fifo_pkg.sv
package dma_thresh_fifo_pkg;
  parameter int unsigned FIFO_DEPTH = 32;
  parameter int unsigned DATA_W     = 16;
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH);
  localparam int unsigned CNT_W     = LVL_W + 1;
  localparam int unsigned CFG_W     = 16;

  // configuration word field positions
  localparam int unsigned RX_DMA_BIT = 15;
  localparam int unsigned AF_LSB     = 8;
  localparam int unsigned TX_DMA_BIT = 7;
  localparam int unsigned AE_LSB     = 0;

  typedef struct packed {
    logic pushEn;
    logic popEn;
    logic pushFromCpu;
  } fifoStrobes_t;

  typedef struct packed {
    logic             rxDmaEn;
    logic [LVL_W-1:0] afLevel;
    logic             txDmaEn;
    logic [LVL_W-1:0] aeLevel;
  } bufCfg_t;
endpackage

// File: rtl/dma_thresh_fifo_dp.sv
module dma_thresh_fifo_dp
  import dma_thresh_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned DW    = DATA_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fifoStrobes_t                 stb,
  input  logic [DW-1:0]                cpuWdata,
  input  logic [DW-1:0]                engPushData,
  output logic [DW-1:0]                rdData,
  output logic [$clog2(DEPTH):0]       fillCount
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CW    = PTR_W + 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr, headNext, tailNext;
  logic [DW-1:0]    pushData;

  // pointer wrap: a power-of-two depth wraps by itself
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2Wrap
      assign headNext = headPtr + 1'b1;
      assign tailNext = tailPtr + 1'b1;
    end else begin : g_cmpWrap
      assign headNext = (headPtr == PTR_W'(DEPTH-1)) ? '0 : headPtr + 1'b1;
      assign tailNext = (tailPtr == PTR_W'(DEPTH-1)) ? '0 : tailPtr + 1'b1;
    end
  endgenerate

  assign pushData = stb.pushFromCpu ? cpuWdata : engPushData;
  assign rdData   = mem[headPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.pushEn) begin
      mem[tailPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      fillCount <= '0;
    end else begin
      if (stb.pushEn) tailPtr <= tailNext;
      if (stb.popEn)  headPtr <= headNext;
      case ({stb.pushEn, stb.popEn})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // R3: the count never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  // R5: accepted push and pop together hold the count
  p_pushpop_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushEn && stb.popEn) |=> (fillCount == $past(fillCount)));

  // R4: no pop accepted means the head word stays on the read port
  p_head_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.popEn && !stb.pushEn) |=> $stable(rdData));
endmodule

// File: rtl/dma_thresh_fifo_ctrl.sv
module dma_thresh_fifo_ctrl
  import dma_thresh_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [CFG_W-1:0]       cfgWdata,
  input  logic                   xferActive,
  input  logic                   xferDirRx,
  input  logic                   cpuWr,
  input  logic                   cpuRd,
  input  logic                   engPush,
  input  logic                   engPop,
  input  logic [$clog2(DEPTH):0] fillCount,
  output fifoStrobes_t           stb,
  output logic                   rxDmaReq,
  output logic                   txDmaReq,
  output logic                   rxLevelFlag,
  output logic                   txLevelFlag
);
  localparam int unsigned LW = $clog2(DEPTH);
  localparam int unsigned CW = LW + 1;

  bufCfg_t cfgReg;
  logic    isFull, isEmpty, idle, rxHit, txHit;
  logic    rxEnWrite, txEnWrite;

  assign isFull    = (fillCount == CW'(DEPTH));
  assign isEmpty   = (fillCount == '0);
  assign idle      = !xferActive && isEmpty;
  assign rxHit     = xferDirRx  && (fillCount > CW'(cfgReg.afLevel));
  assign txHit     = !xferDirRx && (fillCount < CW'(cfgReg.aeLevel));
  assign rxEnWrite = cfgWe && cfgWdata[RX_DMA_BIT];
  assign txEnWrite = cfgWe && cfgWdata[TX_DMA_BIT];

  always_comb begin
    stb.pushEn      = (cpuWr || engPush) && !isFull;
    stb.popEn       = (cpuRd || engPop) && !isEmpty;
    stb.pushFromCpu = cpuWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg.rxDmaEn <= 1'b0;
      cfgReg.afLevel <= LW'(DEPTH-1);
      cfgReg.txDmaEn <= 1'b0;
      cfgReg.aeLevel <= '0;
    end else if (cfgWe) begin
      cfgReg.rxDmaEn <= cfgWdata[RX_DMA_BIT];
      cfgReg.afLevel <= cfgWdata[AF_LSB +: LW];
      cfgReg.txDmaEn <= cfgWdata[TX_DMA_BIT];
      cfgReg.aeLevel <= cfgWdata[AE_LSB +: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLevelFlag <= 1'b0;
      txLevelFlag <= 1'b0;
      rxDmaReq    <= 1'b0;
      txDmaReq    <= 1'b0;
    end else if (idle) begin
      rxLevelFlag <= 1'b0;
      txLevelFlag <= 1'b0;
    end else begin
      rxLevelFlag <= rxHit && !cfgReg.rxDmaEn && !rxEnWrite;
      rxDmaReq    <= rxHit && cfgReg.rxDmaEn;
      txLevelFlag <= txHit && !cfgReg.txDmaEn && !txEnWrite;
      txDmaReq    <= txHit && cfgReg.txDmaEn;
    end
  end

  // R3: nothing enters a full buffer
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !stb.pushEn);

  // R4: nothing leaves an empty buffer
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !stb.popEn);

  // R6: receive flag and request never together
  p_rx_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(rxLevelFlag && rxDmaReq));

  // R7: transmit flag and request never together
  p_tx_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(txLevelFlag && txDmaReq));

  // R8: idle clears flags and holds requests
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && fillCount == '0) |=> (!rxLevelFlag && !txLevelFlag));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && fillCount == '0) |=> ($stable(rxDmaReq) && $stable(txDmaReq)));

  // R9: enable-bit configuration writes clear the matching flag
  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgWdata[RX_DMA_BIT]) |=> !rxLevelFlag);
  p_cfg_clear_tx_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgWdata[TX_DMA_BIT]) |=> !txLevelFlag);
endmodule

// File: rtl/dma_thresh_fifo.sv
module dma_thresh_fifo
  import dma_thresh_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned DW    = DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [CFG_W-1:0]       cfgWdata,
  input  logic                   xferActive,
  input  logic                   xferDirRx,
  input  logic                   cpuWr,
  input  logic [DW-1:0]          cpuWdata,
  input  logic                   cpuRd,
  input  logic                   engPush,
  input  logic [DW-1:0]          engPushData,
  input  logic                   engPop,
  output logic [DW-1:0]          rdData,
  output logic [$clog2(DEPTH):0] fillCount,
  output logic                   rxDmaReq,
  output logic                   txDmaReq,
  output logic                   rxLevelFlag,
  output logic                   txLevelFlag
);
  fifoStrobes_t stb;

  dma_thresh_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .xferActive(xferActive), .xferDirRx(xferDirRx),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .engPush(engPush), .engPop(engPop),
    .fillCount(fillCount), .stb(stb),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .rxLevelFlag(rxLevelFlag), .txLevelFlag(txLevelFlag)
  );

  dma_thresh_fifo_dp #(.DEPTH(DEPTH), .DW(DW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cpuWdata(cpuWdata), .engPushData(engPushData),
    .rdData(rdData), .fillCount(fillCount)
  );
endmodule

// File: tb/test_dma_thresh_fifo.sv
module test_dma_thresh_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic        xferActive = 1'b0, xferDirRx = 1'b0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0, engPush = 1'b0, engPop = 1'b0;
  logic [15:0] cpuWdata = '0, engPushData = '0;
  logic [15:0] rdData;
  logic [5:0]  fillCount;
  logic        rxDmaReq, txDmaReq, rxLevelFlag, txLevelFlag;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [15:0] mdl [32];
  int mHead = 0, mTail = 0, mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_thresh_fifo i_dma_thresh_fifo (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .xferActive(xferActive), .xferDirRx(xferDirRx),
    .cpuWr(cpuWr), .cpuWdata(cpuWdata), .cpuRd(cpuRd),
    .engPush(engPush), .engPushData(engPushData), .engPop(engPop),
    .rdData(rdData), .fillCount(fillCount),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .rxLevelFlag(rxLevelFlag), .txLevelFlag(txLevelFlag)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doPush(bit useEng, logic [15:0] d);
    if (useEng) begin engPush = 1; engPushData = d; end
    else begin cpuWr = 1; cpuWdata = d; end
    step();
    engPush = 0; cpuWr = 0;
    if (mCnt < 32) begin mdl[mTail] = d; mTail = (mTail + 1) % 32; mCnt++; end
  endtask

  task automatic doPop(bit useEng, string req);
    chk(req, rdData, mdl[mHead]);
    if (useEng) engPop = 1; else cpuRd = 1;
    step();
    engPop = 0; cpuRd = 0;
    if (mCnt > 0) begin mHead = (mHead + 1) % 32; mCnt--; end
  endtask

  task automatic cfgWrite(bit rxEn, int af, bit txEn, int ae);
    cfgWe = 1;
    cfgWdata = {rxEn, 2'b00, 5'(af), txEn, 2'b00, 5'(ae)};
    step();
    cfgWe = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", fillCount, 0);
    chk("R1 rdData", rdData, 0);
    chk("R1 outs", {rxDmaReq, txDmaReq, rxLevelFlag, txLevelFlag}, 0);
  endtask

  task automatic t_fill_full();
    xferActive = 1; xferDirRx = 1;
    for (int i = 0; i < 31; i++) doPush(i[0], 16'h1000 + 16'(i));
    step();
    chk("R1 af default below", rxLevelFlag, 0);
    doPush(0, 16'h101F);
    chk("R10 lag", rxLevelFlag, 0);
    step();
    chk("R1 af default hit R6", rxLevelFlag, 1);
    chk("R3 count full", fillCount, 32);
    doPush(0, 16'hDEAD);
    chk("R3 drop", fillCount, 32);
    for (int i = 0; i < 32; i++) doPop(i[1], "R2 order");
    chk("R2 drained", fillCount, 0);
    xferActive = 0;
    step();
  endtask

  task automatic t_wrap_empty();
    for (int i = 0; i < 20; i++) doPush(i[0], 16'h2000 + 16'(i));
    for (int i = 0; i < 20; i++) doPop(i[0], "R2 wrap order");
    chk("R4 empty head word", rdData, mdl[mHead]);
    cpuRd = 1; step(); cpuRd = 0;
    chk("R4 count stays", fillCount, 0);
    chk("R4 head word stays", rdData, mdl[mHead]);
    doPush(1, 16'h1234);
    chk("R4 pointers kept", rdData, 16'h1234);
    chk("R4 count one", fillCount, 1);
  endtask

  task automatic t_pushpop();
    for (int i = 0; i < 4; i++) doPush(0, 16'h3000 + 16'(i));
    chk("R5 pre", fillCount, 5);
    cpuWr = 1; cpuWdata = 16'h3AAA; engPop = 1;
    step();
    cpuWr = 0; engPop = 0;
    mHead = (mHead + 1) % 32; mdl[mTail] = 16'h3AAA; mTail = (mTail + 1) % 32;
    chk("R5 count held", fillCount, 5);
    for (int i = 0; i < 5; i++) doPop(1, "R5 order");
    chk("R5 drained", fillCount, 0);
  endtask

  task automatic t_rx();
    xferActive = 1; xferDirRx = 1;
    cfgWrite(0, 3, 0, 0);
    for (int i = 0; i < 4; i++) doPush(1, 16'h4000 + 16'(i));
    chk("R10 rx lag", rxLevelFlag, 0);
    step();
    chk("R6 rx flag", rxLevelFlag, 1);
    cfgWrite(1, 3, 0, 0);
    chk("R9 rx flag cleared", rxLevelFlag, 0);
    chk("R9 rx req old cfg", rxDmaReq, 0);
    step();
    chk("R6 rx req", rxDmaReq, 1);
    chk("R6 rx flag off", rxLevelFlag, 0);
    doPop(0, "R2 rx pop");
    chk("R10 rx req lag", rxDmaReq, 1);
    step();
    chk("R6 rx req drop", rxDmaReq, 0);
    for (int i = 0; i < 3; i++) doPop(0, "R2 rx pop");
  endtask

  task automatic t_tx();
    xferDirRx = 0;
    cfgWrite(0, 31, 0, 2);
    chk("R10 tx old cfg", txLevelFlag, 0);
    step();
    chk("R7 tx flag", txLevelFlag, 1);
    doPush(0, 16'h5000);
    doPush(0, 16'h5001);
    chk("R10 tx lag", txLevelFlag, 1);
    step();
    chk("R7 tx flag drop", txLevelFlag, 0);
    cfgWrite(0, 31, 1, 4);
    chk("R9 tx req old cfg", txDmaReq, 0);
    step();
    chk("R7 tx req", txDmaReq, 1);
    chk("R7 tx flag off", txLevelFlag, 0);
  endtask

  task automatic t_idle();
    doPop(1, "R2 tx pop");
    doPop(1, "R2 tx pop");
    step();
    chk("R7 tx req empty", txDmaReq, 1);
    xferActive = 0;
    step(); step();
    chk("R8 req held", txDmaReq, 1);
    chk("R8 flag clear", txLevelFlag, 0);
    cfgWrite(0, 31, 0, 4);
    step();
    chk("R8 req held idle cfg", txDmaReq, 1);
    xferActive = 1;
    step();
    chk("R7 req off no dma", txDmaReq, 0);
    chk("R7 flag on", txLevelFlag, 1);
    xferActive = 0;
    step();
    chk("R8 flag forced clear", txLevelFlag, 0);
    chk("R8 rx flag clear", rxLevelFlag, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) step();
    rstN = 1;
    step();
    t_reset();
    t_fill_full();
    t_wrap_empty();
    t_pushpop();
    t_rx();
    t_tx();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule